// File: doc/BRIEF.md
# Wavefront Memory Issue Gate

This block sits beside the instruction buffer of one SIMD thread group. Each cycle it decides whether the instruction at the head of that buffer may issue. The head instruction can be an ALU operation, a barrier, a return, or a memory access. A memory access is a read, a write or an atomic, and it targets one of four spaces: global, private, local or flat. The decision is combinational from the current state. The scheduler raises `pick` to take the instruction, and the block then produces a one-cycle `issue` strobe.

On the clock edge of an issue, the block starts two kinds of timer. One holds the memory bus busy. The other holds the issue slot busy, which spaces issues evenly. The same edge also bumps the request ledgers. There are four ledgers: global read, global write, local read and local write. Each ledger keeps an in-pipe count and an outstanding count. A `req_sent` strobe moves one request from in-pipe to outstanding, and a `req_done` strobe retires one outstanding request.

Ordering between reads and writes inside a memory space is enforced by these counts alone; there is no address compare. Operand dependence checks and request-FIFO space are supplied as ready inputs.

Each hold timer is a two-state machine:
- **T_FREE**: no hold is running.
- **T_BUSY**: a hold is running; the remaining count is kept while busy.

It has four transitions:
- *load*: T_FREE to T_BUSY on an issue that uses this timer.
- *count*: stay in T_BUSY and decrement the remaining count.
- *expire*: T_BUSY to T_FREE when the remaining count is zero.
- *reload*: stay in T_BUSY, taken only if a load arrives while busy.

Top module: `wave_issue_gate`

## Requirements
- R1: `ready` is 0 whenever any of the following holds: `wave_run` is 0, `ibuf_valid` is 0, `head_cls` is 7, or a memory class has `head_acc` equal to 3. `issue` equals `ready` AND `pick`.
- R2: An ALU instruction (`head_cls` 0) needs the ALU issue slot free and `opnd_ok`. Issuing an ALU (0), barrier (1) or return (2) instruction holds the ALU slot busy for ISSUE_GAP cycles.
- R3: A global (3) or private (4) read (`head_acc` 0) or atomic (2) is not ready while the global write ledger holds any in-pipe or outstanding request.
- R4: A global or private write (`head_acc` 1) or atomic is not ready while the global read ledger holds any in-pipe or outstanding request.
- R5: A local (5) access follows the same two rules, using the local read and local write ledgers. Global traffic never blocks a local access, and local traffic never blocks a global access.
- R6: An issued read raises only the read ledger of its space and a write only the write ledger. An atomic raises both.
- R7: A barrier or return is ready only when all four ledgers are empty, counting both in-pipe and outstanding requests.
- R8: After a memory issue, the bus of the space it used is busy for RD_HOLD cycles (4) for a read and WR_HOLD cycles (8) for a write or atomic. During that time no access that needs this bus is ready.
- R9: A flat (6) access needs all of the following: both buses free, both memory issue slots free, `gfifo_ok`, `lfifo_ok` and `opnd_ok`. `flat_lcl` selects whether the local (1) or global (0) bus and slot are held. A flat access is always counted in the global ledgers.
- R10: The `req_sent` and `req_done` bit order is global read (0), global write (1), local read (2), local write (3). A `req_sent` bit moves one request from in-pipe to outstanding, and only if the in-pipe count is nonzero. A `req_done` bit retires one outstanding request. Counts saturate at their maximum and never go below zero.
- R11: `slot_ok` 0 blocks every class. A global or private access also needs `gfifo_ok` and `opnd_ok`, and a local access needs `lfifo_ok` and `opnd_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wave_run | input | 1 | Wave is running, neither stopped nor returning |
| ibuf_valid | input | 1 | Instruction buffer holds a head instruction |
| slot_ok | input | 1 | External issue-slot permission |
| opnd_ok | input | 1 | Operands of the head instruction are ready |
| gfifo_ok | input | 1 | Global request FIFO has space |
| lfifo_ok | input | 1 | Local request FIFO has space |
| head_cls | input | 3 | Class of the head instruction: 0 ALU, 1 barrier, 2 return, 3 global, 4 private, 5 local, 6 flat |
| head_acc | input | 2 | Access kind: 0 read, 1 write, 2 atomic |
| flat_lcl | input | 1 | Flat access executes in local space |
| pick | input | 1 | Scheduler selects this wave |
| req_sent | input | 4 | Per-ledger strobe: request moved from in-pipe to outstanding |
| req_done | input | 4 | Per-ledger strobe: outstanding request retired |
| ready | output | 1 | Head instruction may issue |
| issue | output | 1 | Head instruction issues this cycle |

## Verification
The bench sweeps every ordered pair of access kinds in each memory space. It checks the second access after the first is in flight, again once the first has moved to outstanding, and again once it has retired. A design that only looked at the in-pipe count would let a dependent access pass early. A design that mixed up spaces would let private traffic slip past global writes, or let global reads block local writes.

The bench counts the busy cycles of each hold timer and compares them against the 4 and 8 cycle bus holds and the issue gap; an off-by-one in a timer shows up as a wrong count. The ledgers are driven past saturation and are sent retire strobes while already empty. A wrapping counter would unblock writes too early, and an underflowing one would stall barriers forever. Flat accesses are checked for their need of both FIFOs, for which bus they hold, and for being counted as global traffic.

// File: rtl/wig_pkg.sv
`timescale 1ns/1ps
package wig_pkg;

    typedef enum logic [2:0] {
        CL_ALU  = 3'd0,
        CL_BAR  = 3'd1,
        CL_RET  = 3'd2,
        CL_GLB  = 3'd3,
        CL_PRV  = 3'd4,
        CL_LCL  = 3'd5,
        CL_FLAT = 3'd6,
        CL_NONE = 3'd7
    } cls_e;

    typedef enum logic [1:0] {
        AC_RD  = 2'd0,
        AC_WR  = 2'd1,
        AC_AT  = 2'd2,
        AC_BAD = 2'd3
    } acc_e;

    // ledger indices, shared by strobes and busy vectors
    localparam int ST_GRD = 0;
    localparam int ST_GWR = 1;
    localparam int ST_LRD = 2;
    localparam int ST_LWR = 3;
    localparam int NUM_ST = 4;

    // timer indices
    localparam int TM_ALU  = 0;
    localparam int TM_GSLT = 1;
    localparam int TM_LSLT = 2;
    localparam int TM_GBUS = 3;
    localparam int TM_LBUS = 4;
    localparam int NUM_TM  = 5;

endpackage

// File: rtl/wig_hold_timer.sv
`timescale 1ns/1ps
module wig_hold_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] len,
    output logic          busy
);

    typedef enum logic {T_FREE, T_BUSY} tstate_e;

    tstate_e       st_q, st_d;
    logic [TW-1:0] left_q, left_d;

    always_comb begin
        st_d   = st_q;
        left_d = left_q;
        unique case (st_q)
            T_FREE: begin
                if (load) begin
                    st_d   = T_BUSY;
                    left_d = len - TW'(1);
                end
            end
            T_BUSY: begin
                if (load) begin
                    left_d = len - TW'(1);
                end else if (left_q == '0) begin
                    st_d = T_FREE;
                end else begin
                    left_d = left_q - TW'(1);
                end
            end
            default: st_d = T_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= T_FREE;
            left_q <= '0;
        end else begin
            st_q   <= st_d;
            left_q <= left_d;
        end
    end

    always_comb begin
        busy = (st_q == T_BUSY);
    end

endmodule

// File: rtl/wig_ledger.sv
`timescale 1ns/1ps
module wig_ledger #(
    parameter int CW = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic sent,
    input  logic done,
    output logic busy
);

    localparam logic [CW-1:0] CMAX = '1;

    logic [CW-1:0] pipe_q, pipe_d;
    logic [CW-1:0] out_q, out_d;
    logic          move, retire;

    always_comb begin
        move   = sent && (pipe_q != '0);
        retire = done && (out_q != '0);

        pipe_d = pipe_q;
        unique case ({inc, move})
            2'b10:   pipe_d = (pipe_q == CMAX) ? pipe_q : pipe_q + CW'(1);
            2'b01:   pipe_d = pipe_q - CW'(1);
            default: pipe_d = pipe_q;
        endcase

        out_d = out_q;
        unique case ({move, retire})
            2'b10:   out_d = (out_q == CMAX) ? out_q : out_q + CW'(1);
            2'b01:   out_d = out_q - CW'(1);
            default: out_d = out_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
            out_q  <= '0;
        end else begin
            pipe_q <= pipe_d;
            out_q  <= out_d;
        end
    end

    always_comb begin
        busy = (pipe_q != '0) || (out_q != '0);
    end

endmodule

// File: rtl/wig_issue_check.sv
`timescale 1ns/1ps
module wig_issue_check
    import wig_pkg::*;
(
    input  logic [2:0]        head_cls,
    input  logic [1:0]        head_acc,
    input  logic              flat_lcl,
    input  logic              wave_run,
    input  logic              ibuf_valid,
    input  logic              slot_ok,
    input  logic              opnd_ok,
    input  logic              gfifo_ok,
    input  logic              lfifo_ok,
    input  logic              pick,
    input  logic [NUM_ST-1:0] st_busy,
    input  logic [NUM_TM-1:0] tm_busy,
    output logic              ready,
    output logic              issue,
    output logic [NUM_TM-1:0] tm_load,
    output logic              long_hold,
    output logic [NUM_ST-1:0] st_inc
);

    cls_e cls;
    acc_e acc;
    logic wants_rd, wants_wr, acc_ok, base, rdy;
    logic g_order, l_order, ctl_cls, mem_cls, to_lcl, lcl_space;

    always_comb begin
        cls      = cls_e'(head_cls);
        acc      = acc_e'(head_acc);
        wants_rd = (acc == AC_RD) || (acc == AC_AT);
        wants_wr = (acc == AC_WR) || (acc == AC_AT);
        acc_ok   = (acc != AC_BAD);
        base     = wave_run && ibuf_valid && slot_ok;

        // read waits on writes, write waits on reads, per space
        g_order = !(wants_rd && st_busy[ST_GWR]) && !(wants_wr && st_busy[ST_GRD]);
        l_order = !(wants_rd && st_busy[ST_LWR]) && !(wants_wr && st_busy[ST_LRD]);

        rdy = 1'b0;
        unique case (cls)
            CL_ALU:         rdy = !tm_busy[TM_ALU] && opnd_ok;
            CL_BAR, CL_RET: rdy = !tm_busy[TM_ALU] && (st_busy == '0);
            CL_GLB, CL_PRV: rdy = acc_ok && g_order && opnd_ok && gfifo_ok
                                  && !tm_busy[TM_GSLT] && !tm_busy[TM_GBUS];
            CL_LCL:         rdy = acc_ok && l_order && opnd_ok && lfifo_ok
                                  && !tm_busy[TM_LSLT] && !tm_busy[TM_LBUS];
            CL_FLAT:        rdy = acc_ok && opnd_ok && gfifo_ok && lfifo_ok
                                  && !tm_busy[TM_GSLT] && !tm_busy[TM_GBUS]
                                  && !tm_busy[TM_LSLT] && !tm_busy[TM_LBUS];
            default:        rdy = 1'b0;
        endcase

        ready = base && rdy;
        issue = ready && pick;
    end

    always_comb begin
        ctl_cls   = (cls == CL_ALU) || (cls == CL_BAR) || (cls == CL_RET);
        mem_cls   = (cls == CL_GLB) || (cls == CL_PRV) || (cls == CL_LCL) || (cls == CL_FLAT);
        to_lcl    = (cls == CL_LCL) || ((cls == CL_FLAT) && flat_lcl);
        lcl_space = (cls == CL_LCL);
        long_hold = !(acc == AC_RD);

        tm_load          = '0;
        tm_load[TM_ALU]  = issue && ctl_cls;
        tm_load[TM_GSLT] = issue && mem_cls && !to_lcl;
        tm_load[TM_GBUS] = issue && mem_cls && !to_lcl;
        tm_load[TM_LSLT] = issue && mem_cls && to_lcl;
        tm_load[TM_LBUS] = issue && mem_cls && to_lcl;

        st_inc         = '0;
        st_inc[ST_GRD] = issue && mem_cls && !lcl_space && wants_rd;
        st_inc[ST_GWR] = issue && mem_cls && !lcl_space && wants_wr;
        st_inc[ST_LRD] = issue && lcl_space && wants_rd;
        st_inc[ST_LWR] = issue && lcl_space && wants_wr;
    end

endmodule

// File: rtl/wave_issue_gate.sv
`timescale 1ns/1ps
module wave_issue_gate
    import wig_pkg::*;
#(
    parameter int CW        = 6,
    parameter int ISSUE_GAP = 4,
    parameter int RD_HOLD   = 4,
    parameter int WR_HOLD   = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wave_run,
    input  logic       ibuf_valid,
    input  logic       slot_ok,
    input  logic       opnd_ok,
    input  logic       gfifo_ok,
    input  logic       lfifo_ok,
    input  logic [2:0] head_cls,
    input  logic [1:0] head_acc,
    input  logic       flat_lcl,
    input  logic       pick,
    input  logic [3:0] req_sent,
    input  logic [3:0] req_done,
    output logic       ready,
    output logic       issue
);

    localparam int HOLD_A   = (RD_HOLD > WR_HOLD) ? RD_HOLD : WR_HOLD;
    localparam int HOLD_MAX = (HOLD_A > ISSUE_GAP) ? HOLD_A : ISSUE_GAP;
    localparam int TW       = $clog2(HOLD_MAX + 1);

    logic [NUM_ST-1:0] strm_busy;
    logic [NUM_ST-1:0] strm_inc;
    logic [NUM_TM-1:0] tmr_busy;
    logic [NUM_TM-1:0] tmr_load;
    logic [TW-1:0]     tmr_len [NUM_TM];
    logic              long_hold;

    wig_issue_check u_check (
        .head_cls   (head_cls),
        .head_acc   (head_acc),
        .flat_lcl   (flat_lcl),
        .wave_run   (wave_run),
        .ibuf_valid (ibuf_valid),
        .slot_ok    (slot_ok),
        .opnd_ok    (opnd_ok),
        .gfifo_ok   (gfifo_ok),
        .lfifo_ok   (lfifo_ok),
        .pick       (pick),
        .st_busy    (strm_busy),
        .tm_busy    (tmr_busy),
        .ready      (ready),
        .issue      (issue),
        .tm_load    (tmr_load),
        .long_hold  (long_hold),
        .st_inc     (strm_inc)
    );

    generate
        for (genvar s = 0; s < NUM_ST; s++) begin : g_ledger
            wig_ledger #(.CW(CW)) u_ledger (
                .clk   (clk),
                .rst_n (rst_n),
                .inc   (strm_inc[s]),
                .sent  (req_sent[s]),
                .done  (req_done[s]),
                .busy  (strm_busy[s])
            );
        end

        for (genvar t = 0; t < NUM_TM; t++) begin : g_timer
            if (t == TM_GBUS || t == TM_LBUS) begin : g_bus
                always_comb tmr_len[t] = long_hold ? TW'(WR_HOLD) : TW'(RD_HOLD);
            end else begin : g_slot
                always_comb tmr_len[t] = TW'(ISSUE_GAP);
            end
            wig_hold_timer #(.TW(TW)) u_timer (
                .clk   (clk),
                .rst_n (rst_n),
                .load  (tmr_load[t]),
                .len   (tmr_len[t]),
                .busy  (tmr_busy[t])
            );
        end
    endgenerate

endmodule

// File: rtl/wig_checker.sv
`timescale 1ns/1ps
module wig_checker
    import wig_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wave_run,
    input logic              ibuf_valid,
    input logic [2:0]        head_cls,
    input logic [1:0]        head_acc,
    input logic              ready,
    input logic              issue,
    input logic [NUM_ST-1:0] strm_busy,
    input logic [NUM_TM-1:0] tmr_busy
);

    logic is_gp, is_lcl, is_ctl, gbus_user, not_wr, not_rd;

    always_comb begin
        is_gp     = (head_cls == CL_GLB) || (head_cls == CL_PRV);
        is_lcl    = (head_cls == CL_LCL);
        is_ctl    = (head_cls == CL_ALU) || (head_cls == CL_BAR) || (head_cls == CL_RET);
        gbus_user = is_gp || (head_cls == CL_FLAT);
        not_wr    = (head_acc != AC_WR);
        not_rd    = (head_acc != AC_RD);
    end

    p_idle_wave_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(wave_run && ibuf_valid) |-> !ready);

    p_issue_needs_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> ready);

    p_alu_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && is_ctl) |=> !(ready && is_ctl));

    p_glb_read_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && is_gp && not_wr) |-> !strm_busy[ST_GWR]);

    p_glb_write_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && is_gp && not_rd) |-> !strm_busy[ST_GRD]);

    p_lcl_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && is_lcl) |-> !((not_wr && strm_busy[ST_LWR]) || (not_rd && strm_busy[ST_LRD])));

    p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && (head_cls == CL_BAR || head_cls == CL_RET)) |-> (strm_busy == '0));

    p_bus_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && is_gp) |=> !(ready && gbus_user));

    p_bus_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && is_gp) |=> tmr_busy[TM_GBUS]);

endmodule

bind wave_issue_gate wig_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wave_run   (wave_run),
    .ibuf_valid (ibuf_valid),
    .head_cls   (head_cls),
    .head_acc   (head_acc),
    .ready      (ready),
    .issue      (issue),
    .strm_busy  (strm_busy),
    .tmr_busy   (tmr_busy)
);

// File: tb/wave_issue_gate_tb.sv
`timescale 1ns/1ps
module wave_issue_gate_tb_top;
    import wig_pkg::*;

    localparam int GAP = 2;
    localparam int RDH = 4;
    localparam int WRH = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wave_run = 1'b1, ibuf_valid = 1'b1, slot_ok = 1'b1, opnd_ok = 1'b1;
    logic       gfifo_ok = 1'b1, lfifo_ok = 1'b1, flat_lcl = 1'b0, pick = 1'b0;
    logic [2:0] head_cls = 3'd0;
    logic [1:0] head_acc = 2'd0;
    logic [3:0] req_sent = 4'd0, req_done = 4'd0;
    logic       ready, issue;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    wave_issue_gate #(.CW(2), .ISSUE_GAP(GAP), .RD_HOLD(RDH), .WR_HOLD(WRH)) dut_i (
        .clk(clk), .rst_n(rst_n), .wave_run(wave_run), .ibuf_valid(ibuf_valid),
        .slot_ok(slot_ok), .opnd_ok(opnd_ok), .gfifo_ok(gfifo_ok), .lfifo_ok(lfifo_ok),
        .head_cls(head_cls), .head_acc(head_acc), .flat_lcl(flat_lcl), .pick(pick),
        .req_sent(req_sent), .req_done(req_done), .ready(ready), .issue(issue)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_head(input logic [2:0] c, input logic [1:0] a, input logic f);
        head_cls = c;
        head_acc = a;
        flat_lcl = f;
    endtask

    task automatic probe(input logic [2:0] c, input logic [1:0] a, input logic f,
                         input bit exp, input string req);
        set_head(c, a, f);
        #1;
        check(ready == exp, req, int'(ready), int'(exp));
    endtask

    task automatic fire(input logic [2:0] c, input logic [1:0] a, input logic f, input string req);
        @(negedge clk);
        set_head(c, a, f);
        pick = 1'b1;
        #1;
        check(issue == 1'b1, req, int'(issue), 1);
        @(posedge clk);
        @(negedge clk);
        pick = 1'b0;
    endtask

    task automatic strobe(input logic [3:0] s, input logic [3:0] d);
        @(negedge clk);
        req_sent = s;
        req_done = d;
        @(posedge clk);
        @(negedge clk);
        req_sent = 4'd0;
        req_done = 4'd0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic busy_len(input logic [2:0] c, input logic [1:0] a, input logic f, output int n);
        n = 0;
        set_head(c, a, f);
        #1;
        while (!ready && n < 40) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        logic [3:0] m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state: R1, R7
        probe(CL_ALU, AC_RD, 0, 1, "R1 reset alu");
        check(issue == 1'b0, "R1 reset issue", int'(issue), 0);
        probe(CL_BAR, AC_RD, 0, 1, "R7 reset barrier");
        probe(CL_GLB, AC_AT, 0, 1, "R3 reset atomic");

        // gating: R1, R11
        wave_run = 0; probe(CL_ALU, AC_RD, 0, 0, "R1 stopped"); wave_run = 1;
        ibuf_valid = 0; probe(CL_GLB, AC_RD, 0, 0, "R1 empty buffer"); ibuf_valid = 1;
        probe(CL_NONE, AC_RD, 0, 0, "R1 class 7");
        probe(CL_GLB, AC_BAD, 0, 0, "R1 access 3");
        pick = 1; wave_run = 0; #1;
        check(issue == 1'b0, "R1 pick while not ready", int'(issue), 0);
        wave_run = 1; pick = 0; #1;
        check(issue == 1'b0, "R1 ready without pick", int'(issue), 0);
        slot_ok = 0; probe(CL_BAR, AC_RD, 0, 0, "R11 slot_ok"); slot_ok = 1;
        gfifo_ok = 0; probe(CL_PRV, AC_RD, 0, 0, "R11 gfifo");
        probe(CL_LCL, AC_RD, 0, 1, "R11 gfifo no local effect"); gfifo_ok = 1;
        lfifo_ok = 0; probe(CL_LCL, AC_WR, 0, 0, "R11 lfifo"); lfifo_ok = 1;
        opnd_ok = 0; probe(CL_GLB, AC_WR, 0, 0, "R11 operands");
        probe(CL_ALU, AC_RD, 0, 0, "R2 operands"); opnd_ok = 1;

        // ALU slot gap: R2
        fire(CL_ALU, AC_RD, 0, "R2 alu issue");
        busy_len(CL_ALU, AC_RD, 0, n);
        check(n == GAP, "R2 alu gap", n, GAP);
        fire(CL_BAR, AC_RD, 0, "R2 barrier issue");
        busy_len(CL_RET, AC_RD, 0, n);
        check(n == GAP, "R2 barrier gap", n, GAP);

        // ordering sweep: R3 R4 R6 (global, private) and R5 (local)
        for (int sp = 0; sp < 3; sp++) begin
            for (int a1 = 0; a1 < 3; a1++) begin
                for (int a2 = 0; a2 < 3; a2++) begin
                    logic [2:0] c;
                    bit prev_rd, prev_wr, blk;
                    string tag;
                    c = (sp == 0) ? CL_GLB : (sp == 1) ? CL_PRV : CL_LCL;
                    tag = (sp == 2) ? "R5 local order" : "R3/R4/R6 global order";
                    prev_rd = (a1 != 1);
                    prev_wr = (a1 != 0);
                    blk = ((a2 != 1) && prev_wr) || ((a2 != 0) && prev_rd);
                    m = 4'd0;
                    if (prev_rd) m[(sp == 2) ? 2 : 0] = 1'b1;
                    if (prev_wr) m[(sp == 2) ? 3 : 1] = 1'b1;
                    fire(c, 2'(a1), 0, tag);
                    idle(10);
                    probe(c, 2'(a2), 0, !blk, tag);
                    strobe(m, 4'd0);
                    probe(c, 2'(a2), 0, !blk, "R10 outstanding still blocks");
                    strobe(4'd0, m);
                    probe(c, 2'(a2), 0, 1, "R10 retired unblocks");
                end
            end
        end

        // cross-space: R3, R5
        fire(CL_GLB, AC_WR, 0, "R3 cross setup");
        idle(10);
        probe(CL_PRV, AC_RD, 0, 0, "R3 private waits on global write");
        probe(CL_LCL, AC_RD, 0, 1, "R5 local ignores global write");
        probe(CL_LCL, AC_AT, 0, 1, "R5 local atomic ignores global write");
        strobe(4'b0010, 4'd0); strobe(4'd0, 4'b0010);

        // bus holds: R8
        fire(CL_GLB, AC_RD, 0, "R8 read issue");
        busy_len(CL_GLB, AC_RD, 0, n);
        check(n == RDH, "R8 read hold", n, RDH);
        strobe(4'b0001, 4'd0); strobe(4'd0, 4'b0001);
        fire(CL_GLB, AC_WR, 0, "R8 write issue");
        busy_len(CL_GLB, AC_WR, 0, n);
        check(n == WRH, "R8 write hold", n, WRH);
        strobe(4'b0010, 4'd0); strobe(4'd0, 4'b0010);
        fire(CL_LCL, AC_RD, 0, "R8 local read");
        probe(CL_GLB, AC_RD, 0, 1, "R8 global bus free after local");
        idle(10);
        strobe(4'b0100, 4'd0); strobe(4'd0, 4'b0100);
        fire(CL_LCL, AC_AT, 0, "R8 local atomic");
        busy_len(CL_FLAT, AC_RD, 1, n);
        check(n == WRH, "R8 R9 atomic hold seen by flat", n, WRH);
        probe(CL_LCL, AC_RD, 0, 0, "R6 local atomic sets write");
        probe(CL_LCL, AC_WR, 0, 0, "R6 local atomic sets read");
        strobe(4'b1100, 4'd0); strobe(4'd0, 4'b1100);
        probe(CL_BAR, AC_RD, 0, 1, "R7 drained after atomic");

        // flat: R9
        lfifo_ok = 0; probe(CL_FLAT, AC_RD, 0, 0, "R9 flat needs lfifo"); lfifo_ok = 1;
        gfifo_ok = 0; probe(CL_FLAT, AC_RD, 1, 0, "R9 flat needs gfifo"); gfifo_ok = 1;
        probe(CL_FLAT, AC_RD, 1, 1, "R9 flat ready");
        fire(CL_FLAT, AC_RD, 1, "R9 flat local issue");
        probe(CL_GLB, AC_WR, 0, 0, "R9 flat counted global");
        busy_len(CL_LCL, AC_RD, 0, n);
        check(n == RDH, "R9 flat held local bus", n, RDH);
        probe(CL_LCL, AC_WR, 0, 1, "R9 local ledgers untouched");
        strobe(4'b0001, 4'd0); strobe(4'd0, 4'b0001);
        fire(CL_FLAT, AC_WR, 0, "R9 flat global issue");
        probe(CL_LCL, AC_RD, 0, 1, "R9 local bus free after global flat");
        probe(CL_GLB, AC_WR, 0, 0, "R9 global bus held");
        probe(CL_FLAT, AC_RD, 1, 0, "R9 flat blocked by global bus");
        idle(10);
        probe(CL_GLB, AC_RD, 0, 0, "R9 flat write counted global");
        strobe(4'b0010, 4'd0); strobe(4'd0, 4'b0010);

        // barrier drain: R7
        fire(CL_GLB, AC_RD, 0, "R7 setup");
        idle(10);
        probe(CL_BAR, AC_RD, 0, 0, "R7 barrier in-pipe");
        strobe(4'b0001, 4'd0);
        probe(CL_RET, AC_RD, 0, 0, "R7 return outstanding");
        strobe(4'd0, 4'b0001);
        probe(CL_BAR, AC_RD, 0, 1, "R7 barrier drained");
        fire(CL_LCL, AC_WR, 0, "R7 local setup");
        idle(10);
        probe(CL_RET, AC_RD, 0, 0, "R7 return waits on local");
        strobe(4'b1000, 4'd0); strobe(4'd0, 4'b1000);
        probe(CL_RET, AC_RD, 0, 1, "R7 return drained");

        // saturation: R10 (CW=2, max 3)
        for (int i = 0; i < 5; i++) begin
            fire(CL_GLB, AC_RD, 0, "R10 saturate issue");
            idle(RDH);
        end
        for (int i = 0; i < 5; i++) strobe(4'b0001, 4'd0);
        strobe(4'd0, 4'b0001);
        strobe(4'd0, 4'b0001);
        probe(CL_GLB, AC_WR, 0, 0, "R10 saturated count kept");
        strobe(4'd0, 4'b0001);
        probe(CL_GLB, AC_WR, 0, 1, "R10 saturated count drained");

        // underflow: R10
        strobe(4'b1111, 4'b1111);
        probe(CL_GLB, AC_WR, 0, 1, "R10 no underflow global");
        probe(CL_LCL, AC_WR, 0, 1, "R10 no underflow local");
        probe(CL_BAR, AC_RD, 0, 1, "R10 no underflow barrier");
        fire(CL_GLB, AC_RD, 0, "R10 sent+done setup");
        strobe(4'b0001, 4'b0001);
        probe(CL_BAR, AC_RD, 0, 0, "R10 done before outstanding ignored");
        strobe(4'd0, 4'b0001);
        probe(CL_BAR, AC_RD, 0, 1, "R10 final drain");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule